// File: doc/BRIEF.md
# Trimmed One-Second Prescaler with Test Pin

This block turns a 32768 Hz oscillator enable into a single-cycle one-second tick for a real-time clock. It keeps its place in a 64-minute correction cycle, and in selected minutes it stretches or trims one second by a power-of-two number of oscillator counts. A real crystal's drift can then be cancelled digitally, with no analog trimming. The correction is set by a 5-bit magnitude and a direction bit taken from the control byte.

The same control byte drives an open-drain pin. With the test-enable bit set, the pin carries a square wave taken straight from the oscillator enable, and that wave ignores the correction. With the test-enable bit clear, the pin shows the static level bit. A stop input freezes the whole chain, which saves power on the shelf. When stop is released, a fresh second and a fresh minute begin, at the same position in the 64-minute cycle.

Control byte layout: bits 4..0 hold the trim magnitude N (unsigned, 0..31). Bit 5 sets the direction (1 = speed up, 0 = slow down). Bit 6 enables the test wave. Bit 7 is the static pin level.

Top module: `trim_prescaler`

## Requirements
- R1: A second that is not trimmed lasts exactly 2^PRESCALE_LOG2 enabled oscillator cycles (32768 by default). Each second ends with `tick_1hz` high for exactly one clock, in the clock after the enable that completes it.
- R2: After SECS_PER_MIN ticks the 6-bit minute position `min_idx` advances by one, wrapping from 63 to 0. It changes only in the clock in which `tick_1hz` is high. It is 0 after reset.
- R3: With bit 5 = 1 and magnitude N, the first second of each minute m with m < 2·N is shortened by 2^TRIM_LOG2 cycles (256 by default).
- R4: With bit 5 = 0 and magnitude N, the first second of each minute m with m < 2·N is lengthened by 2^(TRIM_LOG2-1) cycles (128 by default).
- R5: Minutes with m ≥ 2·N, and all seconds after the first in a minute, are never trimmed. With N = 31, minutes 62 and 63 stay nominal.
- R6: The trim settings are captured only when a new minute starts (and while stop is high). A change in the middle of a minute, including during its first second, first acts at the start of the next minute.
- R7: While `stop` is 1, no tick is produced and `min_idx` holds. When `stop` is cleared, counting restarts from the start of a second and of a minute, and the first second lasts the full length that the trim settings give it.
- R8: With bit 6 = 1, the pin drive changes state every 2^FT_LOG2 enabled cycles (a 512 Hz wave by default), whatever the trim magnitude and direction.
- R9: With bit 6 = 0, `pin_low` equals the inverse of bit 7, one clock after the control byte is applied (1 = pull the pin low, 0 = release it).
- R10: During and right after reset, `tick_1hz` is 0, `min_idx` is 0 and `pin_low` is 0 (the pin is released). Trim settings reset to zero.
- R11: Clocks with `osc_en` low do not advance the divider. With enables on every second clock, each second takes twice as many clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | One-clock enable per oscillator cycle |
| stop | input | 1 | Freezes divider, second and minute counters |
| ctrl | input | 8 | Control byte: trim magnitude, direction, test enable, pin level |
| tick_1hz | output | 1 | One-clock pulse at the end of each second |
| min_idx | output | 6 | Position in the 64-minute correction cycle |
| pin_low | output | 1 | Open-drain drive: 1 pulls the pin low |

## Verification
The bench walks full 64-minute cycles with the largest negative trim and with a small positive trim, and measures every second. A design that compared against N instead of 2·N, or that trimmed minutes 62 and 63, would show the wrong lengths at the edge of the window. It changes the magnitude during the first second of a minute: a design that applied the new value at once would shorten that second, where a correct one holds the old length until the next minute. It stops the block halfway through a second and checks that no tick leaks and that the next second is counted from zero. It also runs with sparse oscillator enables. Finally, it times the test wave while the maximum trim is set, so a wave derived from the trimmed divider would show a wrong spacing.

// File: rtl/trim_prescaler_pkg.sv
package trim_prescaler_pkg;

  localparam int MIN_W = 6;
  localparam int MAG_W = 5;

  typedef struct packed {
    logic             speed_up;
    logic [MAG_W-1:0] mag;
  } trim_cfg_t;

  // Split the trim-related bits out of the control byte.
  function automatic trim_cfg_t decode_trim(input logic [7:0] c);
    trim_cfg_t t;
    t.speed_up = c[5];
    t.mag      = c[4:0];
    return t;
  endfunction

  // A minute is trimmed when its position lies below twice the magnitude.
  function automatic logic in_trim_window(input logic [MIN_W-1:0] m,
                                          input logic [MAG_W-1:0] mag);
    return m < {mag, 1'b0};
  endfunction

endpackage

// File: rtl/tp_second_div.sv
module tp_second_div
  import trim_prescaler_pkg::*;
#(
  parameter int PRESCALE_LOG2 = 15,
  parameter int TRIM_LOG2     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic stop,
  input  logic trim_now,
  input  logic trim_up,
  output logic sec_done,
  output logic tick_q
);

  localparam int CNT_W   = PRESCALE_LOG2 + 1;
  localparam int NOM_I   = 1 << PRESCALE_LOG2;
  localparam int SHORT_I = NOM_I - (1 << TRIM_LOG2);
  localparam int LONG_I  = NOM_I + (1 << (TRIM_LOG2 - 1));
  localparam logic [CNT_W-1:0] LEN_NOM   = CNT_W'(NOM_I);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_I);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(LONG_I);

  // Length of the current second in oscillator cycles.
  function automatic logic [CNT_W-1:0] second_len(input logic trim,
                                                  input logic up);
    if (!trim)   return LEN_NOM;
    else if (up) return LEN_SHORT;
    else         return LEN_LONG;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             step;

  assign last_cnt = second_len(trim_now, trim_up) - CNT_W'(1);
  assign step     = osc_en && !stop;
  assign sec_done = step && (cnt_q >= last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (stop) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= sec_done ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= sec_done;
  end

endmodule

// File: rtl/tp_minute_seq.sv
module tp_minute_seq
  import trim_prescaler_pkg::*;
#(
  parameter int SECS_PER_MIN = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  input  logic             sec_done,
  input  trim_cfg_t        cfg_in,
  output logic [MIN_W-1:0] min_q,
  output logic             min_done,
  output logic             trim_active,
  output logic             trim_up
);

  localparam int SEC_W = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECS_PER_MIN - 1);

  logic [SEC_W-1:0] sec_q;
  trim_cfg_t        cfg_q;
  logic             first_sec;

  assign min_done    = sec_done && (sec_q == SEC_LAST);
  assign first_sec   = (sec_q == '0);
  assign trim_active = first_sec && in_trim_window(min_q, cfg_q.mag);
  assign trim_up     = cfg_q.speed_up;

  // Second position inside the minute; a stop starts a fresh minute.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
    end else if (stop) begin
      sec_q <= '0;
    end else if (sec_done) begin
      sec_q <= (sec_q == SEC_LAST) ? '0 : sec_q + SEC_W'(1);
    end
  end

  // Minute position in the 64-minute cycle, wrapping naturally.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        min_q <= '0;
    else if (min_done) min_q <= min_q + MIN_W'(1);
  end

  // Trim settings are sampled only at minute boundaries or while halted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cfg_q <= '0;
    else if (stop || min_done) cfg_q <= cfg_in;
  end

endmodule

// File: rtl/tp_test_pin.sv
module tp_test_pin #(
  parameter int FT_LOG2 = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic stop,
  input  logic test_en,
  input  logic level,
  output logic pin_low
);

  logic [FT_LOG2-1:0] ph_q;
  logic               wave_q;
  logic               ph_wrap;

  assign ph_wrap = osc_en && !stop && (&ph_q);

  // Free-running phase counter fed by the raw oscillator enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      wave_q <= 1'b0;
    end else if (osc_en && !stop) begin
      ph_q <= ph_q + FT_LOG2'(1);
      if (ph_wrap) wave_q <= !wave_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pin_low <= 1'b0;
    else if (test_en) pin_low <= wave_q;
    else              pin_low <= !level;
  end

endmodule

// File: rtl/trim_prescaler.sv
module trim_prescaler
  import trim_prescaler_pkg::*;
#(
  parameter int PRESCALE_LOG2 = 15,
  parameter int TRIM_LOG2     = 8,
  parameter int SECS_PER_MIN  = 60,
  parameter int FT_LOG2       = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       stop,
  input  logic [7:0] ctrl,
  output logic       tick_1hz,
  output logic [5:0] min_idx,
  output logic       pin_low
);

  trim_cfg_t cfg_in;
  logic      sec_done;
  logic      min_done;
  logic      trim_active;
  logic      trim_up;

  assign cfg_in = decode_trim(ctrl);

  tp_second_div #(
    .PRESCALE_LOG2(PRESCALE_LOG2),
    .TRIM_LOG2    (TRIM_LOG2)
  ) div_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .osc_en  (osc_en),
    .stop    (stop),
    .trim_now(trim_active),
    .trim_up (trim_up),
    .sec_done(sec_done),
    .tick_q  (tick_1hz)
  );

  tp_minute_seq #(
    .SECS_PER_MIN(SECS_PER_MIN)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop       (stop),
    .sec_done   (sec_done),
    .cfg_in     (cfg_in),
    .min_q      (min_idx),
    .min_done   (min_done),
    .trim_active(trim_active),
    .trim_up    (trim_up)
  );

  tp_test_pin #(
    .FT_LOG2(FT_LOG2)
  ) pin_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .osc_en (osc_en),
    .stop   (stop),
    .test_en(ctrl[6]),
    .level  (ctrl[7]),
    .pin_low(pin_low)
  );

endmodule

// File: rtl/trim_prescaler_chk.sv
module trim_prescaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_en,
  input logic       stop,
  input logic [7:0] ctrl,
  input logic       tick_1hz,
  input logic [5:0] min_idx,
  input logic       pin_low,
  input logic       sec_done,
  input logic       min_done,
  input logic       trim_active
);

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |=> !tick_1hz);

  assert_min_moves_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    min_done |-> sec_done);

  assert_min_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    min_done |=> (min_idx == $past(min_idx) + 6'd1) && tick_1hz);

  assert_window_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trim_active |-> (min_idx < 6'd62));

  assert_stop_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !tick_1hz);

  assert_stop_holds_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> $stable(min_idx));

  assert_level_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[6] |=> (pin_low == !$past(ctrl[7])));

  assert_idle_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !tick_1hz);

endmodule

bind trim_prescaler trim_prescaler_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .osc_en     (osc_en),
  .stop       (stop),
  .ctrl       (ctrl),
  .tick_1hz   (tick_1hz),
  .min_idx    (min_idx),
  .pin_low    (pin_low),
  .sec_done   (sec_done),
  .min_done   (min_done),
  .trim_active(trim_active)
);

// File: tb/trim_prescaler_tb_top.sv
module trim_prescaler_tb_top;

  localparam int TB_P   = 6;
  localparam int TB_T   = 3;
  localparam int TB_SPM = 4;
  localparam int TB_F   = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       osc_en;
  logic       stop;
  logic [7:0] ctrl;
  logic       tick_1hz;
  logic [5:0] min_idx;
  logic       pin_low;

  int total = 0;
  int bad   = 0;
  bit gap_mode = 1'b0;

  int          m_sec = 0;
  int          m_min = 0;
  logic [4:0]  lat_mag = '0;
  logic        lat_up  = 1'b0;

  always #10 clk = ~clk;

  trim_prescaler #(
    .PRESCALE_LOG2(TB_P),
    .TRIM_LOG2    (TB_T),
    .SECS_PER_MIN (TB_SPM),
    .FT_LOG2      (TB_F)
  ) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .osc_en  (osc_en),
    .stop    (stop),
    .ctrl    (ctrl),
    .tick_1hz(tick_1hz),
    .min_idx (min_idx),
    .pin_low (pin_low)
  );

  always @(negedge clk) osc_en <= gap_mode ? ~osc_en : 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len();
    if (m_sec == 0 && m_min < 2 * int'(lat_mag))
      return lat_up ? (1 << TB_P) - (1 << TB_T) : (1 << TB_P) + (1 << (TB_T - 1));
    return 1 << TB_P;
  endfunction

  task automatic measure(output int n, input int chg_at, input logic [7:0] chg_val);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == chg_at) ctrl = chg_val;
    end while (!tick_1hz && n < 5000);
  endtask

  task automatic advance();
    if (m_sec == TB_SPM - 1) begin
      m_sec = 0;
      m_min = (m_min + 1) % 64;
      lat_mag = ctrl[4:0];
      lat_up  = ctrl[5];
      chk(min_idx == 6'(m_min), "R2 minute position", int'(min_idx), m_min);
    end else begin
      m_sec++;
    end
  endtask

  task automatic run_secs(input int count, input int scale, input bit skip_first,
                          input string req);
    for (int i = 0; i < count; i++) begin
      int e;
      int n;
      e = exp_len() * scale;
      measure(n, -1, 8'h00);
      if (!(skip_first && i == 0)) chk(n == e, req, n, e);
      advance();
    end
  endtask

  task automatic halt();
    @(negedge clk);
    stop = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic resume();
    @(negedge clk);
    stop = 1'b0;
    m_sec = 0;
    lat_mag = ctrl[4:0];
    lat_up  = ctrl[5];
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(tick_1hz == 1'b0, "R10 tick in reset", int'(tick_1hz), 0);
    chk(min_idx == 6'd0, "R10 minute in reset", int'(min_idx), 0);
    chk(pin_low == 1'b0, "R10 pin in reset", int'(pin_low), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pin_low == 1'b0, "R10 pin after reset", int'(pin_low), 0);
    chk(min_idx == 6'd0, "R10 minute after reset", int'(min_idx), 0);
  endtask

  task automatic t_nominal();
    ctrl = 8'h80;
    resume();
    run_secs(2 * TB_SPM, 1, 1'b0, "R1 nominal second");
  endtask

  task automatic t_positive();
    halt();
    ctrl = 8'hA1;
    resume();
    run_secs(64 * TB_SPM, 1, 1'b0, "R3 speed-up cycle");
  endtask

  task automatic t_negative();
    halt();
    ctrl = 8'h9F;
    resume();
    run_secs(64 * TB_SPM, 1, 1'b0, "R4 R5 slow-down cycle");
  endtask

  task automatic t_midchange();
    int n;
    int e;
    halt();
    ctrl = 8'h80;
    resume();
    e = exp_len();
    measure(n, 10, 8'hA3);
    chk(n == e, "R6 change inside first second", n, e);
    advance();
    run_secs(TB_SPM - 1, 1, 1'b0, "R6 rest of minute");
    run_secs(TB_SPM, 1, 1'b0, "R6 next minute trimmed");
  endtask

  task automatic t_stop();
    int n;
    int ticks;
    logic [5:0] m0;
    measure(n, -1, 8'h00);
    advance();
    repeat (20) @(negedge clk);
    stop = 1'b1;
    m0 = min_idx;
    ticks = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tick_1hz) ticks++;
    end
    chk(ticks == 0, "R7 no tick while stopped", ticks, 0);
    chk(min_idx == m0, "R7 minute held", int'(min_idx), int'(m0));
    resume();
    run_secs(TB_SPM + 1, 1, 1'b0, "R7 restart from zero");
  endtask

  task automatic t_gap();
    gap_mode = 1'b1;
    run_secs(4, 2, 1'b1, "R11 sparse enables");
    gap_mode = 1'b0;
    run_secs(2, 1, 1'b1, "R11 dense enables");
  endtask

  task automatic t_testwave();
    logic prev;
    int   n;
    ctrl = 8'hFF;
    repeat (3) @(negedge clk);
    prev = pin_low;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (pin_low == prev && n < 100);
    for (int k = 0; k < 6; k++) begin
      prev = pin_low;
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (pin_low == prev && n < 100);
      chk(n == (1 << TB_F), "R8 test wave spacing", n, 1 << TB_F);
    end
  endtask

  task automatic t_level();
    @(negedge clk);
    ctrl = 8'h00;
    @(negedge clk);
    chk(pin_low == 1'b1, "R9 level 0 pulls low", int'(pin_low), 1);
    ctrl = 8'h80;
    @(negedge clk);
    chk(pin_low == 1'b0, "R9 level 1 releases", int'(pin_low), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    stop   = 1'b1;
    ctrl   = 8'h80;
    osc_en = 1'b1;
    t_reset();
    t_nominal();
    t_positive();
    t_negative();
    t_midchange();
    t_stop();
    t_gap();
    t_testwave();
    t_level();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule